// File: doc/BRIEF.md
# Interleaved-Bank Vector Address Generator

This block turns one vector memory operation into a stream of per-element requests for a memory built from interleaved banks of 64-bit words. Software-visible setup arrives as a single start pulse carrying an addressing mode, a byte base address, a signed element stride, an element-size code and an active element count. The generator then walks the elements in ascending order and presents, for each one, the bank number, the word address inside that bank, the byte lane inside the word and the element number. Downstream logic takes each request over a valid/ready handshake.

Three addressing modes are supported. In the contiguous mode, element addresses advance by the element size. In the strided mode, they advance by a signed stride counted in elements. In the indexed mode, each address is the base plus an unsigned byte offset taken from a separate index stream. A bank that has just accepted a request stays occupied for a fixed number of cycles. Any later element that maps to that bank waits until the bank is free, and later elements are never reordered around it. A contiguous operation whose base is not on a 64-bit boundary is refused with a one-cycle error pulse.

Top module: `vec_addr_gen`

## Requirements
- R1: After reset, `req_valid`, `idx_ready`, `busy`, `done` and `err` are all low.
- R2: `start` is taken only while `busy` is low, and `busy` stays high from the accepted start until the last request has been accepted. A `start` raised while busy has no effect on the request stream. While `busy` is low, `req_valid` and `idx_ready` stay low.
- R3: Mode code 0 (and the spare code 3) is contiguous: element i sits at byte address base + i * 2^esize. The code `esize` 0,1,2,3 means 1, 2, 4 or 8 bytes.
- R4: Mode code 1 is strided: element i sits at base + i * stride * 2^esize. `stride` is a two's-complement count of elements, and the result wraps at the address width, so negative strides walk downward.
- R5: Mode code 2 is indexed: element i sits at base + x_i. Here x_i is the i-th value accepted on the index stream (`idx_valid` and `idx_ready` both high), read as an unsigned byte offset. Exactly one index is consumed per element, in order.
- R6: For a byte address A, `req_lane` is A[2:0], `req_bank` is A[6:3] (16 banks), and `req_word` is A[31:7].
- R7: Requests are accepted in ascending element order starting at 0, with `req_elem` equal to the element number. When banks do not collide and `req_ready` stays high, one request is accepted every cycle.
- R8: While `req_valid` is high and `req_ready` is low, the request fields hold steady and `req_valid` stays high.
- R9: Two accepted requests to the same bank are at least BUSY_CYC (default 4) cycles apart. With `req_ready` held high, an element held back by its bank is accepted exactly BUSY_CYC cycles after the previous acceptance at that bank.
- R10: In contiguous mode, a base with A[2:0] not zero produces a one-cycle `err` pulse in the cycle after start, and no requests and no `done`.
- R11: `done` pulses for one cycle in the cycle after the request for element vl-1 is accepted. A start with vl = 0 issues no requests and pulses `done` in the cycle after start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation with the setup values below |
| mode | input | 2 | 0 contiguous, 1 strided, 2 indexed, 3 as 0 |
| base | input | 32 | Byte base address |
| stride | input | 16 | Signed stride in elements (strided mode) |
| esize | input | 2 | log2 of element bytes |
| vl | input | 8 | Active element count |
| idx_valid | input | 1 | Index stream valid |
| idx_data | input | 16 | Unsigned byte offset for the next element |
| idx_ready | output | 1 | Index value consumed this cycle |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted by memory side |
| req_bank | output | 4 | Bank number |
| req_word | output | 25 | Word address inside the bank |
| req_lane | output | 3 | Byte offset inside the 64-bit word |
| req_elem | output | 8 | Element number |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last request accepted (pulse) |
| err | output | 1 | Misaligned contiguous base (pulse) |

## Verification
Contiguous 8-byte elements spread across all banks and wrap back to bank 0 after sixteen. This separates the one-per-cycle rate from any stall logic. Contiguous 4-byte elements put two elements in every word, so each pair collides, and the exact acceptance span shows whether the bank wait is too short or too long. A stride of sixteen words lands every element on one bank. Positive and negative strides with sub-word elements check the signed scaling and wraparound. The indexed pattern uses scattered offsets, an index stream with gaps and a memory side that stalls at random. Together these test index ordering against the handshake hold. Three further cases cover operations that must not produce requests: a misaligned contiguous base, a zero count, and a start raised during a run.

// File: rtl/vag_pkg.sv
package vag_pkg;
  typedef enum logic [1:0] {
    AM_CONTIG = 2'd0,
    AM_STRIDE = 2'd1,
    AM_INDEX  = 2'd2,
    AM_SPARE  = 2'd3
  } amode_e;

  // byte-offset bits inside one 64-bit bank word
  localparam int LANE_W = 3;
endpackage

// File: rtl/vag_addr_unit.sv
module vag_addr_unit
  import vag_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 16,
  parameter int IDX_W    = 16
) (
  input  amode_e              mode,
  input  logic [1:0]          esize,
  input  logic [STRIDE_W-1:0] stride,
  input  logic [ADDR_W-1:0]   base,
  input  logic [ADDR_W-1:0]   cur_addr,
  input  logic [IDX_W-1:0]    idx_data,
  output logic [ADDR_W-1:0]   cand_addr,
  output logic [ADDR_W-1:0]   step
);
  logic [ADDR_W-1:0] stride_sx;

  assign stride_sx = {{(ADDR_W-STRIDE_W){stride[STRIDE_W-1]}}, stride};

  always_comb begin
    unique case (mode)
      AM_STRIDE: step = stride_sx << esize;
      AM_INDEX:  step = '0;
      default:   step = ADDR_W'(1) << esize;
    endcase
  end

  assign cand_addr = (mode == AM_INDEX) ? base + ADDR_W'(idx_data) : cur_addr;
endmodule

// File: rtl/vag_bank_track.sv
module vag_bank_track #(
  parameter int NUM_BANKS = 16,
  parameter int BUSY_CYC  = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CNT_W    = $clog2(BUSY_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [BANK_W-1:0] fire_bank,
  input  logic [BANK_W-1:0] query_bank,
  output logic              free
);
  localparam bit SAME_BLOCK = (BUSY_CYC > 1);

  logic [CNT_W-1:0] cnt [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)
        cnt[b] <= '0;
      else if (fire && fire_bank == BANK_W'(b))
        cnt[b] <= CNT_W'(BUSY_CYC - 1);
      else if (cnt[b] != '0)
        cnt[b] <= cnt[b] - CNT_W'(1);
    end
  end

  // a request loaded now is accepted one edge later at the earliest
  assign free = (cnt[query_bank] <= CNT_W'(1)) &&
                !(SAME_BLOCK && fire && fire_bank == query_bank);
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
  import vag_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int STRIDE_W  = 16,
  parameter int IDX_W     = 16,
  parameter int VL_W      = 8,
  parameter int NUM_BANKS = 16,
  parameter int BUSY_CYC  = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int BWORD_W  = ADDR_W - LANE_W - BANK_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [1:0]          mode,
  input  logic [ADDR_W-1:0]   base,
  input  logic [STRIDE_W-1:0] stride,
  input  logic [1:0]          esize,
  input  logic [VL_W-1:0]     vl,
  input  logic                idx_valid,
  input  logic [IDX_W-1:0]    idx_data,
  output logic                idx_ready,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [BANK_W-1:0]   req_bank,
  output logic [BWORD_W-1:0]  req_word,
  output logic [LANE_W-1:0]   req_lane,
  output logic [VL_W-1:0]     req_elem,
  output logic                busy,
  output logic                done,
  output logic                err
);
  logic                run;
  amode_e              r_mode;
  logic [1:0]          r_esize;
  logic [STRIDE_W-1:0] r_stride;
  logic [ADDR_W-1:0]   r_base;
  logic [VL_W-1:0]     r_vl;
  logic [ADDR_W-1:0]   cur_addr;
  logic [VL_W-1:0]     next_elem;
  logic                req_last;

  logic [ADDR_W-1:0]   cand_addr;
  logic [ADDR_W-1:0]   step;
  logic [BANK_W-1:0]   cand_bank;
  logic                bank_free;
  logic                slot_free;
  logic                cand_ok;
  logic                load;
  logic                fire;
  logic                is_last;
  logic                contig_req;

  vag_addr_unit #(
    .ADDR_W  (ADDR_W),
    .STRIDE_W(STRIDE_W),
    .IDX_W   (IDX_W)
  ) u_addr (
    .mode     (r_mode),
    .esize    (r_esize),
    .stride   (r_stride),
    .base     (r_base),
    .cur_addr (cur_addr),
    .idx_data (idx_data),
    .cand_addr(cand_addr),
    .step     (step)
  );

  assign cand_bank = cand_addr[LANE_W +: BANK_W];

  vag_bank_track #(
    .NUM_BANKS(NUM_BANKS),
    .BUSY_CYC (BUSY_CYC)
  ) u_banks (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .fire_bank (req_bank),
    .query_bank(cand_bank),
    .free      (bank_free)
  );

  assign fire       = req_valid && req_ready;
  assign slot_free  = !req_valid || req_ready;
  assign cand_ok    = (r_mode != AM_INDEX) || idx_valid;
  assign load       = run && slot_free && cand_ok && bank_free;
  assign is_last    = (next_elem == r_vl - VL_W'(1));
  assign idx_ready  = run && (r_mode == AM_INDEX) && slot_free && bank_free;
  assign busy       = run || req_valid;
  assign contig_req = (amode_e'(mode) == AM_CONTIG) || (amode_e'(mode) == AM_SPARE);

  // operation control and running address
  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      r_mode    <= AM_CONTIG;
      r_esize   <= '0;
      r_stride  <= '0;
      r_base    <= '0;
      r_vl      <= '0;
      cur_addr  <= '0;
      next_elem <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= fire && req_last;
      err  <= 1'b0;
      if (!busy && start) begin
        if (contig_req && base[LANE_W-1:0] != '0) begin
          err <= 1'b1;
        end else if (vl == '0) begin
          done <= 1'b1;
        end else begin
          run       <= 1'b1;
          r_mode    <= amode_e'(mode);
          r_esize   <= esize;
          r_stride  <= stride;
          r_base    <= base;
          r_vl      <= vl;
          cur_addr  <= base;
          next_elem <= '0;
        end
      end else if (load) begin
        cur_addr  <= cur_addr + step;
        next_elem <= next_elem + VL_W'(1);
        if (is_last)
          run <= 1'b0;
      end
    end
  end

  // registered request slot
  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_bank  <= '0;
      req_word  <= '0;
      req_lane  <= '0;
      req_elem  <= '0;
      req_last  <= 1'b0;
    end else if (load) begin
      req_valid <= 1'b1;
      req_bank  <= cand_bank;
      req_word  <= cand_addr[ADDR_W-1 -: BWORD_W];
      req_lane  <= cand_addr[LANE_W-1:0];
      req_elem  <= next_elem;
      req_last  <= is_last;
    end else if (fire) begin
      req_valid <= 1'b0;
      req_last  <= 1'b0;
    end
  end
endmodule

// File: rtl/vag_checker.sv
module vag_checker #(
  parameter int ADDR_W    = 32,
  parameter int VL_W      = 8,
  parameter int NUM_BANKS = 16,
  parameter int BUSY_CYC  = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int BWORD_W  = ADDR_W - 3 - BANK_W,
  localparam int GAP_W    = $clog2(BUSY_CYC + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic [BANK_W-1:0]  req_bank,
  input logic [BWORD_W-1:0] req_word,
  input logic [2:0]         req_lane,
  input logic [VL_W-1:0]    req_elem,
  input logic               idx_ready,
  input logic               busy,
  input logic               done,
  input logic               err
);
  logic            fire;
  logic [GAP_W-1:0] since [NUM_BANKS];
  logic [VL_W-1:0] last_elem;

  assign fire = req_valid && req_ready;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_gap
    always_ff @(posedge clk) begin
      if (rst)
        since[b] <= GAP_W'(BUSY_CYC);
      else if (fire && req_bank == BANK_W'(b))
        since[b] <= GAP_W'(1);
      else if (since[b] < GAP_W'(BUSY_CYC))
        since[b] <= since[b] + GAP_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      last_elem <= '0;
    else if (fire)
      last_elem <= req_elem;
  end

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_bank) && $stable(req_word)
                                && $stable(req_lane) && $stable(req_elem)); // R8

  AST_BANK_GAP: assert property (@(posedge clk) disable iff (rst)
    fire |-> since[req_bank] >= GAP_W'(BUSY_CYC)); // R9

  AST_ELEM_STEP: assert property (@(posedge clk) disable iff (rst)
    fire |-> (req_elem == '0) || (req_elem == last_elem + VL_W'(1))); // R7

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    err |-> !req_valid && !busy && !done); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_valid && !busy); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !req_valid && !idx_ready); // R2
endmodule

bind vec_addr_gen vag_checker #(
  .ADDR_W   (ADDR_W),
  .VL_W     (VL_W),
  .NUM_BANKS(NUM_BANKS),
  .BUSY_CYC (BUSY_CYC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_bank (req_bank),
  .req_word (req_word),
  .req_lane (req_lane),
  .req_elem (req_elem),
  .idx_ready(idx_ready),
  .busy     (busy),
  .done     (done),
  .err      (err)
);

// File: tb/vec_addr_gen_test.sv
module vec_addr_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY       = 4;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [31:0] base = '0;
  logic [15:0] stride = '0;
  logic [1:0]  esize = '0;
  logic [7:0]  vl = '0;
  logic        idx_valid = 1'b0;
  logic [15:0] idx_data = '0;
  logic        idx_ready;
  logic        req_valid;
  logic        req_ready = 1'b1;
  logic [3:0]  req_bank;
  logic [24:0] req_word;
  logic [2:0]  req_lane;
  logic [7:0]  req_elem;
  logic        busy, done, err;

  vec_addr_gen uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .base(base),
    .stride(stride), .esize(esize), .vl(vl), .idx_valid(idx_valid),
    .idx_data(idx_data), .idx_ready(idx_ready), .req_valid(req_valid),
    .req_ready(req_ready), .req_bank(req_bank), .req_word(req_word),
    .req_lane(req_lane), .req_elem(req_elem), .busy(busy), .done(done),
    .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int fire_cnt = 0;
  int first_fire = -1;
  int last_fire = -1;
  int done_cnt = 0;
  int done_cyc = -1;
  int err_cnt = 0;
  int idx_cons = 0;
  int bank_last [16];
  logic [63:0] expq [$];
  logic [15:0] idx_arr [16];
  logic [15:0] lfsr = 16'hACE1;
  bit rdy_rand = 0;
  bit idx_rand = 0;
  bit idx_en = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pack_req(input logic [31:0] a, input int e);
    return {27'd0, a[6:3], a[31:7], a[2:0], 8'(e)};
  endfunction

  // scoreboard monitor, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (req_valid && req_ready) begin
        logic [63:0] got;
        got = {27'd0, req_bank, req_word, req_lane, req_elem};
        if (expq.size() == 0) begin
          check(0, "R2/R10 unexpected request", got, 64'd0);
        end else begin
          logic [63:0] exp;
          exp = expq.pop_front();
          check(got == exp, "R3-R7 request fields", got, exp);
        end
        if (bank_last[req_bank] >= 0)
          check(cyc - bank_last[req_bank] >= BUSY, "R9 bank spacing",
                64'(cyc - bank_last[req_bank]), 64'(BUSY));
        bank_last[req_bank] = cyc;
        if (first_fire < 0) first_fire = cyc;
        last_fire = cyc;
        fire_cnt++;
      end
      if (idx_valid && idx_ready) idx_cons++;
      if (done) begin done_cnt++; done_cyc = cyc; end
      if (err) err_cnt++;
    end
  end

  // input drivers for ready and the index stream
  initial begin
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req_ready = rdy_rand ? lfsr[0] : 1'b1;
      idx_valid = idx_en && (idx_rand ? lfsr[3] : 1'b1) && (idx_cons < 16);
      idx_data  = idx_arr[idx_cons % 16];
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic clear_stats();
    fire_cnt = 0; first_fire = -1; last_fire = -1;
    done_cnt = 0; done_cyc = -1; err_cnt = 0; idx_cons = 0;
    for (int b = 0; b < 16; b++) bank_last[b] = -1;
  endtask

  task automatic pulse_start(input logic [1:0] m, input logic [31:0] b,
                             input logic [15:0] s, input logic [1:0] es,
                             input logic [7:0] n);
    @(posedge clk); #1;
    mode = m; base = b; stride = s; esize = es; vl = n; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic push_ops(input logic [1:0] m, input logic [31:0] b,
                          input int s, input int es, input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] a;
      if (m == 2'd1)      a = b + 32'(i * s * (1 << es));
      else if (m == 2'd2) a = b + 32'(idx_arr[i]);
      else                a = b + 32'(i * (1 << es));
      expq.push_back(pack_req(a, i));
    end
  endtask

  task automatic wait_done(input string tag);
    int t = 0;
    while (done_cnt == 0 && t < 3000) begin @(negedge clk); t++; end
    @(negedge clk);
    check(done_cnt == 1, {tag, " R11 single done"}, 64'(done_cnt), 64'd1);
  endtask

  task automatic run_op(input logic [1:0] m, input logic [31:0] b, input int s,
                        input int es, input int n, input string tag);
    clear_stats();
    push_ops(m, b, s, es, n);
    idx_en = (m == 2'd2);
    pulse_start(m, b, 16'(s), 2'(es), 8'(n));
    wait_done(tag);
    idx_en = 0;
    check(fire_cnt == n, {tag, " R7 request count"}, 64'(fire_cnt), 64'(n));
    check(expq.size() == 0, {tag, " R7 all expected seen"}, 64'(expq.size()), 64'd0);
    check(done_cyc == last_fire + 1, {tag, " R11 done timing"},
          64'(done_cyc), 64'(last_fire + 1));
    check(!busy, {tag, " R2 idle after done"}, 64'(busy), 64'd0);
    expq.delete();
  endtask

  initial begin
    for (int b = 0; b < 16; b++) bank_last[b] = -1;
    idx_arr[0] = 16'h0000; idx_arr[1] = 16'h0008; idx_arr[2] = 16'h0040;
    idx_arr[3] = 16'h0010; idx_arr[4] = 16'h0048; idx_arr[5] = 16'h0003;
    idx_arr[6] = 16'h0400; idx_arr[7] = 16'h0088; idx_arr[8] = 16'h1000;
    idx_arr[9] = 16'h0018; idx_arr[10] = 16'hFFF8; idx_arr[11] = 16'h0020;
    for (int i = 12; i < 16; i++) idx_arr[i] = 16'(i * 24);
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!req_valid && !idx_ready && !busy && !done && !err, "R1 reset outputs",
          {59'd0, req_valid, idx_ready, busy, done, err}, 64'd0);

    // R3 R6 R7: 8-byte contiguous, all banks, full rate
    run_op(2'd0, 32'h0000_0100, 0, 3, 20, "contig8");
    check(last_fire - first_fire == 19, "R7 one per cycle", 64'(last_fire - first_fire), 64'd19);

    // R3 R9: 4-byte contiguous, pairs collide in each word
    run_op(2'd0, 32'h0000_2000, 0, 2, 6, "contig4");
    check(last_fire - first_fire == 14, "R9 exact bank wait", 64'(last_fire - first_fire), 64'd14);

    // R4: positive stride
    run_op(2'd1, 32'h0000_0040, 3, 3, 10, "stride+3");

    // R4: negative stride, sub-word, wrap below zero
    run_op(2'd1, 32'h0000_0014, -2, 2, 8, "stride-2");

    // R9: every element on the same bank
    run_op(2'd1, 32'h0000_0800, 16, 3, 5, "samebank");
    check(last_fire - first_fire == 4 * BUSY, "R9 same bank span",
          64'(last_fire - first_fire), 64'(4 * BUSY));

    // R5 R8: indexed with gaps on both sides
    rdy_rand = 1; idx_rand = 1;
    run_op(2'd2, 32'h0000_3000, 0, 3, 12, "indexed");
    check(idx_cons == 12, "R5 index consumed", 64'(idx_cons), 64'd12);
    rdy_rand = 0; idx_rand = 0;

    // R8: stalled strided run
    rdy_rand = 1;
    run_op(2'd1, 32'h0001_0000, 5, 1, 14, "stride-stall");
    rdy_rand = 0;

    // R10: misaligned contiguous base
    clear_stats();
    pulse_start(2'd0, 32'h0000_0104, 0, 3, 8);
    repeat (20) @(negedge clk);
    check(err_cnt == 1, "R10 err pulse", 64'(err_cnt), 64'd1);
    check(fire_cnt == 0, "R10 no requests", 64'(fire_cnt), 64'd0);
    check(done_cnt == 0, "R10 no done", 64'(done_cnt), 64'd0);

    // R11: zero length
    clear_stats();
    pulse_start(2'd1, 32'h0000_0000, 1, 3, 0);
    repeat (10) @(negedge clk);
    check(done_cnt == 1, "R11 zero-length done", 64'(done_cnt), 64'd1);
    check(fire_cnt == 0, "R11 zero-length no requests", 64'(fire_cnt), 64'd0);

    // R2: start while busy ignored
    clear_stats();
    rdy_rand = 1;
    push_ops(2'd0, 32'h0000_0200, 0, 3, 8);
    pulse_start(2'd0, 32'h0000_0200, 0, 3, 8);
    pulse_start(2'd1, 32'h0000_0000, 1, 3, 4);
    wait_done("busy-start");
    rdy_rand = 0;
    repeat (20) @(negedge clk);
    check(fire_cnt == 8, "R2 ignored start", 64'(fire_cnt), 64'd8);
    check(expq.size() == 0, "R2 stream unchanged", 64'(expq.size()), 64'd0);
    check(!busy, "R2 idle at end", 64'(busy), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule